// File: doc/BRIEF.md
# DC-Blocking Filter with Offset Freeze

This block removes the DC component from decimated audio samples, one first-order high-pass section per channel. Each channel keeps a DC estimate in a fixed-point accumulator that behaves as a leaky integrator. It subtracts the estimate, as it stands before the current sample updates it, from every incoming sample and saturates the difference to the sample width. While the `defeat` input is high the estimate is frozen, and the frozen value is still subtracted. This is what lets a system calibrate its offset once and then hold the correction.

After reset the block first waits through a warm-up period counted in samples. At the last warm-up sample it reads `defeat` once to choose one of two start-up paths:
- **Defeat low:** a long settling phase using the normal slow time constant.
- **Defeat high:** a short self-calibration. The block raises `ref_sel` so that the analog front end feeds a common reference in place of the real input, trains the estimate with a fast time constant, then drops `ref_sel` and keeps the learned estimate. After that the estimate stays frozen as long as `defeat` is high.

Output samples are forced to zero until start-up completes. One output sample is produced for each input sample, on the cycle after it is accepted.

Top module: `dcb_filter`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0, `out_data` is all zeros and `ref_sel` is 0. Every channel's accumulator clears to zero.
- R2: Each cycle with `smp_valid` high produces exactly one cycle of `out_valid` high on the next cycle. There is no `out_valid` without an accepted sample.
- R3: Output samples are zero for the first WARM_N + INIT samples after reset. INIT is SETTLE_N on the settling path and CAL_N on the calibration path. Every later sample is unmuted.
- R4: The start-up path is chosen from the `defeat` value at the last warm-up sample (sample index WARM_N-1 counted from 0): 0 selects settling, 1 selects calibration. The choice does not change until the next reset.
- R5: `ref_sel` is 1 exactly while the calibration phase runs: from the cycle after warm-up ends until the cycle after the last calibration sample.
- R6: For each sample that updates the estimate, the accumulator `a` (DW+FRAC bits, signed) becomes `a + (((x << FRAC) - a) >>> k)`, using an arithmetic (floor) shift. k is SHIFT_FAST during calibration and SHIFT_SLOW otherwise. The estimate is `a >>> FRAC`.
- R7: An unmuted output equals the sample minus the estimate held before that sample, saturated to the range from -2^(DW-1) to 2^(DW-1)-1. Channel c occupies bits [c*DW +: DW] of the data buses.
- R8: In the settling and run phases, a sample accepted while `defeat` is 1 leaves the accumulator unchanged, and the held estimate is still subtracted.
- R9: Warm-up samples never change the accumulator.
- R10: Calibration updates the estimate at every calibration sample whatever the value of `defeat`. Once calibration ends, the estimate it learned is subtracted unchanged for as long as `defeat` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defeat | input | 1 | 1 freezes the estimate; at the end of warm-up, also selects self-calibration |
| smp_valid | input | 1 | Marks a new sample set (one per sample period) |
| smp_data | input | NCH*DW | Signed samples, channel c at [c*DW +: DW] |
| out_valid | output | 1 | Output sample set is valid |
| out_data | output | NCH*DW | Signed filtered samples, same packing |
| ref_sel | output | 1 | Selects the common reference at the analog input during calibration |

## Verification
Two functions can fall on the same accepted sample: subtraction of the old estimate and the estimate update. At the final warm-up sample, the path choice and a muted output also coincide. The bench provokes the first by changing the input level and by toggling `defeat` between samples during the run and settling phases. It judges each output against a model that subtracts the estimate from before the update and then advances that estimate. It provokes the second by resetting with `defeat` both low and high, and judges the position of the first unmuted sample and the `ref_sel` window against the sample count. Full-scale inputs set against an estimate of the opposite sign drive the saturation edges.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  // Start-up / operating phases of the DC blocker
  typedef enum logic [1:0] {
    PH_WARM   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CAL    = 2'd2,
    PH_RUN    = 2'd3
  } dcb_phase_e;
endpackage

// File: rtl/dcb_seq.sv
module dcb_seq
  import dcb_pkg::*;
#(
  parameter int WARM_N   = 32,
  parameter int SETTLE_N = 28672,
  parameter int CAL_N    = 4160
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic defeat,
  output logic upd_en,
  output logic fast,
  output logic mute,
  output logic warm,
  output logic ref_sel
);
  localparam int MAX_A = (WARM_N > SETTLE_N) ? WARM_N : SETTLE_N;
  localparam int MAXN  = (MAX_A > CAL_N) ? MAX_A : CAL_N;
  localparam int CW    = $clog2(MAXN + 1);

  dcb_phase_e    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PH_WARM;
      cnt <= '0;
    end else if (smp_valid) begin
      case (st)
        PH_WARM: begin
          if (cnt == CW'(WARM_N - 1)) begin
            cnt <= '0;
            st  <= defeat ? PH_CAL : PH_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt == CW'(SETTLE_N - 1)) begin
            cnt <= '0;
            st  <= PH_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CAL: begin
          if (cnt == CW'(CAL_N - 1)) begin
            cnt <= '0;
            st  <= PH_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          st  <= PH_RUN;
        end
      endcase
    end
  end

  always_comb begin
    warm    = (st == PH_WARM);
    fast    = (st == PH_CAL);
    ref_sel = (st == PH_CAL);
    mute    = (st != PH_RUN);
    case (st)
      PH_CAL:    upd_en = 1'b1;
      PH_SETTLE: upd_en = !defeat;
      PH_RUN:    upd_en = !defeat;
      default:   upd_en = 1'b0;
    endcase
  end

  // R4: once running, the phase never leaves run before a reset
  p_run_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RUN) |=> (st == PH_RUN));
  // R5: the reference is only selected while output is muted
  p_ref_muted_r5: assert property (@(posedge clk) disable iff (rst)
    ref_sel |-> mute);
  // R3: the phase counter only moves on accepted samples
  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(cnt) && $stable(st)));
endmodule

// File: rtl/dcb_chan.sv
module dcb_chan #(
  parameter int DW         = 24,
  parameter int FRAC       = 16,
  parameter int SHIFT_SLOW = 13,
  parameter int SHIFT_FAST = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] x,
  input  logic                 upd_en,
  input  logic                 fast,
  input  logic                 mute,
  input  logic                 warm,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + FRAC;
  localparam logic signed [DW-1:0] Y_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] Y_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] est;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   step;
  logic signed [AW:0]   acc_sum;
  logic signed [DW:0]   res;
  logic signed [DW-1:0] res_sat;

  assign est = acc[AW-1:FRAC];

  always_comb begin
    diff    = $signed({x[DW-1], x, {FRAC{1'b0}}}) - $signed({acc[AW-1], acc});
    step    = fast ? (diff >>> SHIFT_FAST) : (diff >>> SHIFT_SLOW);
    acc_sum = $signed({acc[AW-1], acc}) + step;
  end

  always_comb begin
    res = $signed({x[DW-1], x}) - $signed({est[DW-1], est});
    if (res[DW] != res[DW-1]) res_sat = res[DW] ? Y_MIN : Y_MAX;
    else                      res_sat = res[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      y   <= '0;
    end else if (smp_valid) begin
      if (upd_en) acc <= acc_sum[AW-1:0];
      y <= mute ? '0 : res_sat;
    end
  end

  // R6: the leaky step never leaves the accumulator range
  p_acc_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && upd_en) |-> (acc_sum[AW] == acc_sum[AW-1]));
  // R8: a frozen estimate keeps its value
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !upd_en) |=> $stable(acc));
  // R9: warm-up leaves the accumulator at its reset value
  p_warm_idle_r9: assert property (@(posedge clk) disable iff (rst)
    warm |-> (acc == '0));
  // R3: muted samples produce zero
  p_mute_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mute) |=> (y == '0));
endmodule

// File: rtl/dcb_filter.sv
module dcb_filter #(
  parameter int NCH        = 2,
  parameter int DW         = 24,
  parameter int FRAC       = 16,
  parameter int SHIFT_SLOW = 13,
  parameter int SHIFT_FAST = 6,
  parameter int WARM_N     = 32,
  parameter int SETTLE_N   = 28672,
  parameter int CAL_N      = 4160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              defeat,
  input  logic              smp_valid,
  input  logic [NCH*DW-1:0] smp_data,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data,
  output logic              ref_sel
);
  logic upd_en, fast, mute, warm;

  dcb_seq #(
    .WARM_N  (WARM_N),
    .SETTLE_N(SETTLE_N),
    .CAL_N   (CAL_N)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .smp_valid(smp_valid),
    .defeat   (defeat),
    .upd_en   (upd_en),
    .fast     (fast),
    .mute     (mute),
    .warm     (warm),
    .ref_sel  (ref_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] ch_y;
    dcb_chan #(
      .DW        (DW),
      .FRAC      (FRAC),
      .SHIFT_SLOW(SHIFT_SLOW),
      .SHIFT_FAST(SHIFT_FAST)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .smp_valid(smp_valid),
      .x        (smp_data[c*DW +: DW]),
      .upd_en   (upd_en),
      .fast     (fast),
      .mute     (mute),
      .warm     (warm),
      .y        (ch_y)
    );
    assign out_data[c*DW +: DW] = ch_y;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= smp_valid;
  end

  // R1: reset leaves the outputs quiet
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !ref_sel));
  // R2: one output per accepted sample, one cycle later
  p_one_out_r2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !out_valid);
endmodule

// File: tb/dcb_filter_test.sv
module dcb_filter_test;
  localparam int NCH = 2, DW = 24, FRAC = 16, KS = 13, KF = 6;
  localparam int WARM = 4, SETTLE = 24, CAL = 12;

  logic clk = 0, rst = 1, defeat = 0, smp_valid = 0;
  logic [NCH*DW-1:0] smp_data = '0;
  logic out_valid, ref_sel;
  logic [NCH*DW-1:0] out_data;

  always #2.5 clk = ~clk;

  dcb_filter #(.NCH(NCH), .DW(DW), .FRAC(FRAC), .SHIFT_SLOW(KS), .SHIFT_FAST(KF),
               .WARM_N(WARM), .SETTLE_N(SETTLE), .CAL_N(CAL)) uut (
    .clk(clk), .rst(rst), .defeat(defeat), .smp_valid(smp_valid),
    .smp_data(smp_data), .out_valid(out_valid), .out_data(out_data),
    .ref_sel(ref_sel));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic signed [DW-1:0] q0[$], q1[$];
  string qt[$];
  longint acc[NCH];
  int cnt;
  bit cal_mode;
  string run_tag = "R7";

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int phase_of(int n);
    if (n < WARM) return 0;
    if (n < WARM + (cal_mode ? CAL : SETTLE)) return cal_mode ? 2 : 1;
    return 3;
  endfunction

  function automatic longint sat(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  task automatic do_reset(bit dft);
    @(negedge clk);
    rst = 1; defeat = dft; smp_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_data", out_data, 0);
    check("R1 ref_sel", ref_sel, 0);
    rst = 0;
    @(negedge clk);
    check("R1 ref_sel after release", ref_sel, 0);
    acc[0] = 0; acc[1] = 0; cnt = 0; cal_mode = 0;
  endtask

  task automatic send(int a, int b);
    int ph;
    longint x[NCH];
    longint e[NCH];
    x[0] = a; x[1] = b;
    ph = phase_of(cnt);
    for (int c = 0; c < NCH; c++) begin
      e[c] = (ph == 3) ? sat(x[c] - (acc[c] >>> FRAC)) : 0;
      if (ph == 2) acc[c] += (((x[c] <<< FRAC) - acc[c]) >>> KF);
      else if ((ph == 1 || ph == 3) && !defeat)
        acc[c] += (((x[c] <<< FRAC) - acc[c]) >>> KS);
    end
    if (cnt == WARM - 1) cal_mode = defeat;
    cnt++;
    q0.push_back(DW'(e[0]));
    q1.push_back(DW'(e[1]));
    if (ph == 0)      qt.push_back("R9/R3");
    else if (ph != 3) qt.push_back("R3/R4");
    else              qt.push_back(run_tag);
    smp_data = {DW'(b), DW'(a)};
    smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
    check("R2 out_valid after sample", out_valid, 1);
    check("R5 ref_sel window", ref_sel, (phase_of(cnt) == 2));
    @(negedge clk);
    check("R2 no extra out_valid", out_valid, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q0.size() == 0) begin
        check("R2 unexpected output", 1, 0);
      end else begin
        string t;
        logic signed [DW-1:0] e0, e1;
        e0 = q0.pop_front(); e1 = q1.pop_front(); t = qt.pop_front();
        check({t, " ch0"}, $signed(out_data[DW-1:0]), e0);
        check({t, " ch1"}, $signed(out_data[2*DW-1:DW]), e1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Settling path (R4 with defeat low)
    do_reset(0);
    for (int i = 0; i < WARM + SETTLE; i++) send(1000, -5000);
    run_tag = "R7/R6";
    for (int i = 0; i < 6; i++) send(1000, -5000);
    send(70000, -120000);
    send(-3000, 4000);
    run_tag = "R7 saturation";
    send(-8388608, 8388607);
    send(8388607, -8388608);
    run_tag = "R8 frozen";
    defeat = 1;
    for (int i = 0; i < 5; i++) send(2000 + i * 500, 3000);
    defeat = 0;
    run_tag = "R6 resumed";
    for (int i = 0; i < 4; i++) send(2000, 3000);

    // Calibration path (R4 with defeat high)
    do_reset(1);
    for (int i = 0; i < WARM; i++) send(300, -700);
    for (int i = 0; i < CAL; i++) send(300, -700);
    run_tag = "R10 frozen after calibration";
    for (int i = 0; i < 6; i++) send(300 + i, -700);
    defeat = 0;
    run_tag = "R6 after release";
    for (int i = 0; i < 4; i++) send(5000, -5000);

    repeat (4) @(negedge clk);
    check("R2 queue drained", q0.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule